// File: doc/BRIEF.md
# Priority Chip-Select Bank Decoder

This block decides which of eight programmable memory banks serves a bus access. Each access presents an address, a 3-bit address type, a read/write flag and a flag that says whether an external master drives it. The block compares every access against all banks in the same cycle. A bank takes part only when its valid bit is set. The bank must match the upper address bits under its address mask, and it must match the address type under its type mask. When several banks qualify, the one with the lowest index wins. The decoder then drives a one-hot chip-select along with that bank's port-size and machine-select attributes.

Software programs the banks through a single-cycle register-write port. Each bank has a base word and an option word, and there is one status word. A write that lands on a write-protected bank does not assert a chip-select. It raises a violation pulse instead and sets a sticky status bit, which software clears by writing 1 to it. An access that no bank claims raises a no-match pulse, so the bus can end the cycle with an error. Bank 0 is the boot bank. Out of reset it covers the whole address space. Every result is registered, one clock after the request.

Top module: `cs_bank_decoder`

## Requirements
- R1: The base word holds the bank's upper address in bits [31:15] (17 bits). The option word holds the address mask in bits [31:15]. A bank's address matches when `(req_addr[31:15] & mask) == (base & mask)`, which gives a minimum bank size of 32 KB.
- R2: The base word holds the bank type in bits [14:12]. The option word holds the type mask in bits [14:12]. The type matches when `((req_at ^ bank_type) & type_mask) == 0`.
- R3: The base word holds the valid flag in bit 0. A bank whose valid flag is clear never matches.
- R4: When several banks match, only the lowest-indexed one is selected. `cs_onehot` has bit i set for bank i. `sel_ps` carries that bank's base bits [11:10], and `sel_ms` carries its base bits [9:8].
- R5: When `req_ext` is 1, the type compared is 3'b100 whatever `req_at` holds.
- R6: The base word holds the write-protect flag in bit 1. A write access whose winning bank has that flag set produces `wp_viol`=1, `cs_onehot`=0 and `no_match`=0. A read access to that bank is served normally.
- R7: `wp_status` is set by every violation and stays set until a write to the status word (`reg_addr`=5'b10000) carries 1 in bit 0. If a violation occurs in the same cycle as the clear, the bit stays set.
- R8: A valid access that no bank matches produces `no_match`=1 and `cs_onehot`=0.
- R9: After reset, bank 0 is valid with a zero address mask and zero type mask, so it matches every address, and its port size is `BOOT_PS`. Banks 1..7 reset invalid. All outputs reset to 0.
- R10: For banks 1..7, the valid flag in a base write is stored only if that bank's option word has been written since reset. Otherwise the bank stays invalid. Bank 0 accepts its base word at any time.
- R11: Outputs appear one clock after the request is sampled. A cycle with `req_valid`=0 yields `cs_onehot`=0, `no_match`=0 and `wp_viol`=0 on the next cycle.
- R12: `reg_addr` values with bit 4 clear select bank `reg_addr[3:1]`. Within that bank, `reg_addr[0]`=0 selects the base word and 1 selects the option word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register select (bank, word, status) |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Access address |
| req_at | input | 3 | Access address type |
| req_write | input | 1 | 1 for a write access |
| req_ext | input | 1 | Access driven by an external master |
| rsp_valid | output | 1 | Registered copy of `req_valid` |
| cs_onehot | output | 8 | One-hot chip-select |
| sel_bank | output | 3 | Index of the winning bank |
| sel_ps | output | 2 | Port size of the winning bank |
| sel_ms | output | 2 | Machine select of the winning bank |
| no_match | output | 1 | No bank matched |
| wp_viol | output | 1 | Write-protect violation pulse |
| wp_status | output | 1 | Sticky write-protect error bit |

## Verification
Several properties are checked on every cycle. The chip-select is one-hot or zero and always agrees with the reported bank index. No-match, chip-select and violation exclude one another. A violation only follows a write request and always shows in the sticky bit. The sticky bit never drops without a clear strobe, and idle cycles produce idle outputs. Other behaviours depend on programmed contents, and only the bench scenarios can show them. These are the mask boundaries of a 32 KB bank, lowest-index priority between overlapping banks, the forced type for external masters, the option-before-base rule, and the boot state of bank 0.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int MASK_W = 17;
  localparam int AT_W   = 3;
  localparam int PS_W   = 2;
  localparam int MS_W   = 2;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [MASK_W-1:0] addr;
    logic [AT_W-1:0]   at;
    logic [PS_W-1:0]   ps;
    logic [MS_W-1:0]   ms;
    logic              wp;
    logic              valid;
  } bank_base_t;

  typedef struct packed {
    logic [MASK_W-1:0] amask;
    logic [AT_W-1:0]   atmask;
  } bank_opt_t;

  function automatic bank_base_t unpack_base(input logic [WORD_W-1:0] w);
    bank_base_t b;
    b.addr  = w[WORD_W-1 -: MASK_W];
    b.at    = w[14:12];
    b.ps    = w[11:10];
    b.ms    = w[9:8];
    b.wp    = w[1];
    b.valid = w[0];
    return b;
  endfunction

  function automatic bank_opt_t unpack_opt(input logic [WORD_W-1:0] w);
    bank_opt_t o;
    o.amask  = w[WORD_W-1 -: MASK_W];
    o.atmask = w[14:12];
    return o;
  endfunction
endpackage

// File: rtl/cs_bank_regs.sv
module cs_bank_regs
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter logic [MASK_W-1:0] BOOT_BASE = '0,
  parameter logic [PS_W-1:0]   BOOT_PS   = 2'b01,
  localparam int IDX_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_bank,
  input  logic              wr_opt,
  input  logic [WORD_W-1:0] wr_data,
  output bank_base_t        base_q [NUM_BANKS],
  output bank_opt_t         opt_q  [NUM_BANKS]
);
  bank_base_t new_base;
  bank_opt_t  new_opt;

  always_comb begin
    new_base = unpack_base(wr_data);
    new_opt  = unpack_opt(wr_data);
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bank_base_t base_r;
    bank_opt_t  opt_r;
    logic       opt_seen;
    logic       hit_base, hit_opt;

    assign hit_base = wr_en && (wr_bank == IDX_W'(g)) && !wr_opt;
    assign hit_opt  = wr_en && (wr_bank == IDX_W'(g)) &&  wr_opt;

    if (g == 0) begin : g_boot
      always_ff @(posedge clk) begin
        if (rst) begin
          base_r       <= '0;
          base_r.addr  <= BOOT_BASE;
          base_r.ps    <= BOOT_PS;
          base_r.valid <= 1'b1;
          opt_r        <= '0;
          opt_seen     <= 1'b0;
        end else begin
          if (hit_base) base_r <= new_base;
          if (hit_opt) begin
            opt_r    <= new_opt;
            opt_seen <= 1'b1;
          end
        end
      end
    end else begin : g_std
      always_ff @(posedge clk) begin
        if (rst) begin
          base_r   <= '0;
          opt_r    <= '0;
          opt_seen <= 1'b0;
        end else begin
          if (hit_base) begin
            base_r       <= new_base;
            base_r.valid <= new_base.valid && opt_seen;
          end
          if (hit_opt) begin
            opt_r    <= new_opt;
            opt_seen <= 1'b1;
          end
        end
      end
    end

    assign base_q[g] = base_r;
    assign opt_q[g]  = opt_r;
  end
endmodule

// File: rtl/cs_bank_match.sv
module cs_bank_match
  import cs_dec_pkg::*;
(
  input  bank_base_t        base,
  input  bank_opt_t         opt,
  input  logic [MASK_W-1:0] acc_hi,
  input  logic [AT_W-1:0]   acc_at,
  output logic              hit
);
  logic addr_ok, at_ok;

  always_comb begin
    addr_ok = ((acc_hi & opt.amask) == (base.addr & opt.amask));
    at_ok   = (((acc_at ^ base.at) & opt.atmask) == '0);
    hit     = base.valid && addr_ok && at_ok;
  end
endmodule

// File: rtl/cs_prio_sel.sv
module cs_prio_sel
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int IDX_W = $clog2(NUM_BANKS)
) (
  input  logic [NUM_BANKS-1:0] hits,
  input  bank_base_t           bases [NUM_BANKS],
  output logic                 found,
  output logic [IDX_W-1:0]     idx,
  output logic [NUM_BANKS-1:0] onehot,
  output logic [PS_W-1:0]      ps,
  output logic [MS_W-1:0]      ms,
  output logic                 wp
);
  always_comb begin
    idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
    found  = |hits;
    onehot = found ? (NUM_BANKS'(1) << idx) : '0;
    ps     = bases[idx].ps;
    ms     = bases[idx].ms;
    wp     = bases[idx].wp;
  end
endmodule

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 32,
  parameter logic [MASK_W-1:0] BOOT_BASE = '0,
  parameter logic [PS_W-1:0]   BOOT_PS   = 2'b01,
  parameter logic [AT_W-1:0]   EXT_AT    = 3'b100,
  localparam int IDX_W  = $clog2(NUM_BANKS),
  localparam int RADR_W = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [RADR_W-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [AT_W-1:0]      req_at,
  input  logic                 req_write,
  input  logic                 req_ext,
  output logic                 rsp_valid,
  output logic [NUM_BANKS-1:0] cs_onehot,
  output logic [IDX_W-1:0]     sel_bank,
  output logic [PS_W-1:0]      sel_ps,
  output logic [MS_W-1:0]      sel_ms,
  output logic                 no_match,
  output logic                 wp_viol,
  output logic                 wp_status
);
  bank_base_t base_q [NUM_BANKS];
  bank_opt_t  opt_q  [NUM_BANKS];

  logic status_sel, bank_we, clr_req;
  assign status_sel = reg_addr[RADR_W-1];
  assign bank_we    = reg_we && !status_sel;
  assign clr_req    = reg_we && status_sel && reg_wdata[0];

  cs_bank_regs #(
    .NUM_BANKS (NUM_BANKS),
    .BOOT_BASE (BOOT_BASE),
    .BOOT_PS   (BOOT_PS)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bank_we),
    .wr_bank (reg_addr[IDX_W:1]),
    .wr_opt  (reg_addr[0]),
    .wr_data (reg_wdata),
    .base_q  (base_q),
    .opt_q   (opt_q)
  );

  logic [AT_W-1:0]      eff_at;
  logic [NUM_BANKS-1:0] hits;
  assign eff_at = req_ext ? EXT_AT : req_at;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
    cs_bank_match u_match (
      .base   (base_q[g]),
      .opt    (opt_q[g]),
      .acc_hi (req_addr[ADDR_W-1 -: MASK_W]),
      .acc_at (eff_at),
      .hit    (hits[g])
    );
  end

  logic                 win_found, win_wp;
  logic [IDX_W-1:0]     win_idx;
  logic [NUM_BANKS-1:0] win_oh;
  logic [PS_W-1:0]      win_ps;
  logic [MS_W-1:0]      win_ms;

  cs_prio_sel #(.NUM_BANKS(NUM_BANKS)) u_prio (
    .hits   (hits),
    .bases  (base_q),
    .found  (win_found),
    .idx    (win_idx),
    .onehot (win_oh),
    .ps     (win_ps),
    .ms     (win_ms),
    .wp     (win_wp)
  );

  logic served, viol_now;
  assign served   = req_valid && win_found;
  assign viol_now = served && req_write && win_wp;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      cs_onehot <= '0;
      sel_bank  <= '0;
      sel_ps    <= '0;
      sel_ms    <= '0;
      no_match  <= 1'b0;
      wp_viol   <= 1'b0;
      wp_status <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      cs_onehot <= (served && !viol_now) ? win_oh : '0;
      sel_bank  <= served ? win_idx : '0;
      sel_ps    <= served ? win_ps : '0;
      sel_ms    <= served ? win_ms : '0;
      no_match  <= req_valid && !win_found;
      wp_viol   <= viol_now;
      wp_status <= (wp_status && !clr_req) || viol_now;
    end
  end
endmodule

// File: rtl/cs_dec_checker.sv
module cs_dec_checker #(
  parameter int NUM_BANKS = 8,
  localparam int IDX_W  = $clog2(NUM_BANKS),
  localparam int RADR_W = IDX_W + 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_we,
  input logic [RADR_W-1:0]    reg_addr,
  input logic [31:0]          reg_wdata,
  input logic                 req_valid,
  input logic                 req_write,
  input logic                 rsp_valid,
  input logic [NUM_BANKS-1:0] cs_onehot,
  input logic [IDX_W-1:0]     sel_bank,
  input logic                 no_match,
  input logic                 wp_viol,
  input logic                 wp_status
);
  logic clr_strobe;
  assign clr_strobe = reg_we && reg_addr[RADR_W-1] && reg_wdata[0];

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_onehot));

  p_cs_idx_r4: assert property (@(posedge clk) disable iff (rst)
    (cs_onehot != '0) |-> (cs_onehot == (NUM_BANKS'(1) << sel_bank)));

  p_nomatch_excl_r8: assert property (@(posedge clk) disable iff (rst)
    no_match |-> (cs_onehot == '0 && !wp_viol));

  p_viol_nocs_r6: assert property (@(posedge clk) disable iff (rst)
    wp_viol |-> (cs_onehot == '0));

  p_viol_write_r6: assert property (@(posedge clk) disable iff (rst)
    wp_viol |-> $past(req_valid && req_write));

  p_viol_sets_r7: assert property (@(posedge clk) disable iff (rst)
    wp_viol |-> wp_status);

  p_status_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (wp_status && !clr_strobe) |=> wp_status);

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (cs_onehot == '0 && !no_match && !wp_viol));

  p_rsp_r11: assert property (@(posedge clk) disable iff (rst)
    (cs_onehot != '0 || no_match) |-> rsp_valid);
endmodule

bind cs_bank_decoder cs_dec_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .req_valid (req_valid),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .cs_onehot (cs_onehot),
  .sel_bank  (sel_bank),
  .no_match  (no_match),
  .wp_viol   (wp_viol),
  .wp_status (wp_status)
);

// File: tb/cs_bank_decoder_tb.sv
module cs_bank_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_at = '0;
  logic        req_write = 1'b0;
  logic        req_ext = 1'b0;
  logic        rsp_valid;
  logic [7:0]  cs_onehot;
  logic [2:0]  sel_bank;
  logic [1:0]  sel_ps, sel_ms;
  logic        no_match, wp_viol, wp_status;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cs_bank_decoder u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_at(req_at), .req_write(req_write), .req_ext(req_ext),
    .rsp_valid(rsp_valid), .cs_onehot(cs_onehot), .sel_bank(sel_bank),
    .sel_ps(sel_ps), .sel_ms(sel_ms), .no_match(no_match),
    .wp_viol(wp_viol), .wp_status(wp_status)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] base_w(input logic [16:0] a, input logic [2:0] at,
      input logic [1:0] ps, input logic [1:0] ms, input logic wp, input logic v);
    return {a, at, ps, ms, 6'b0, wp, v};
  endfunction

  function automatic logic [31:0] opt_w(input logic [16:0] m, input logic [2:0] atm);
    return {m, atm, 12'b0};
  endfunction

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // one access; outputs sampled at the negedge after the capturing edge
  task automatic access(input logic [31:0] a, input logic [2:0] at, input logic wr,
      input logic ext, input logic [7:0] exp_cs, input logic exp_nm,
      input logic exp_viol, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_at = at; req_write = wr; req_ext = ext;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_ext = 1'b0;
    chk(32'(cs_onehot), 32'(exp_cs), {tag, " cs_onehot"});
    chk(32'(no_match), 32'(exp_nm), {tag, " no_match"});
    chk(32'(wp_viol), 32'(exp_viol), {tag, " wp_viol"});
  endtask

  task automatic t_reset;
    chk(32'(cs_onehot), 0, "R9 reset cs");
    chk(32'(wp_status), 0, "R9 reset status");
    chk(32'(no_match), 0, "R9 reset no_match");
    access(32'h1234_5678, 3'b011, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, "R9 boot bank any addr");
    chk(32'(sel_ps), 32'h1, "R9 boot port size");
    @(negedge clk);
    chk(32'(cs_onehot), 0, "R11 idle cs");
    chk(32'(no_match), 0, "R11 idle no_match");
  endtask

  task automatic t_addr_mask;
    reg_write(5'b00000, base_w(17'h1FFE0, 3'b000, 2'b01, 2'b00, 1'b0, 1'b1));
    access(32'h0000_1000, 3'b000, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, "R10 bank0 base before option");
    reg_write(5'b00001, opt_w(17'h1FFFF, 3'b000));
    access(32'h0000_1000, 3'b000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R8 outside all banks");
    access(32'hFFF0_7FFC, 3'b000, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, "R1 top of 32KB bank");
    access(32'hFFF0_8000, 3'b000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R1 just past 32KB bank");
  endtask

  task automatic t_order;
    reg_write(5'b00010, base_w(17'h02000, 3'b000, 2'b00, 2'b01, 1'b0, 1'b1));
    access(32'h1000_0000, 3'b000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R10 base before option ignored");
    reg_write(5'b00011, opt_w(17'h1FFFF, 3'b000));
    access(32'h1000_0000, 3'b000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R10 still invalid after option");
    reg_write(5'b00010, base_w(17'h02000, 3'b000, 2'b00, 2'b01, 1'b0, 1'b1));
    access(32'h1000_0000, 3'b000, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, "R12 bank1 valid after order");
  endtask

  task automatic t_valid;
    reg_write(5'b00010, base_w(17'h02000, 3'b000, 2'b00, 2'b01, 1'b0, 1'b0));
    access(32'h1000_0000, 3'b000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R3 valid cleared");
    reg_write(5'b00010, base_w(17'h02000, 3'b000, 2'b00, 2'b01, 1'b0, 1'b1));
  endtask

  task automatic t_priority;
    reg_write(5'b00101, opt_w(17'h1FFFE, 3'b000));
    reg_write(5'b00100, base_w(17'h02000, 3'b000, 2'b10, 2'b11, 1'b0, 1'b1));
    access(32'h1000_0100, 3'b000, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, "R4 overlap lowest wins");
    chk(32'(sel_ps), 32'h0, "R4 ps of bank1");
    chk(32'(sel_ms), 32'h1, "R4 ms of bank1");
    chk(32'(sel_bank), 32'h1, "R4 index bank1");
    access(32'h1000_8000, 3'b000, 1'b0, 1'b0, 8'h04, 1'b0, 1'b0, "R4 only bank2 matches");
    chk(32'(sel_ps), 32'h2, "R4 ps of bank2");
    chk(32'(sel_ms), 32'h3, "R4 ms of bank2");
  endtask

  task automatic t_at;
    reg_write(5'b00111, opt_w(17'h1FFFF, 3'b111));
    reg_write(5'b00110, base_w(17'h04000, 3'b010, 2'b00, 2'b00, 1'b0, 1'b1));
    access(32'h2000_0040, 3'b010, 1'b0, 1'b0, 8'h08, 1'b0, 1'b0, "R2 type equal");
    access(32'h2000_0040, 3'b011, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R2 type differs");
    reg_write(5'b00111, opt_w(17'h1FFFF, 3'b110));
    access(32'h2000_0040, 3'b011, 1'b0, 1'b0, 8'h08, 1'b0, 1'b0, "R2 masked type bit");
  endtask

  task automatic t_ext;
    reg_write(5'b01001, opt_w(17'h1FFFF, 3'b111));
    reg_write(5'b01000, base_w(17'h06000, 3'b100, 2'b00, 2'b00, 1'b0, 1'b1));
    access(32'h3000_0000, 3'b001, 1'b0, 1'b1, 8'h10, 1'b0, 1'b0, "R5 external forced type");
    access(32'h3000_0000, 3'b001, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R5 internal own type");
  endtask

  task automatic t_wp;
    reg_write(5'b01011, opt_w(17'h1FFFF, 3'b000));
    reg_write(5'b01010, base_w(17'h08000, 3'b000, 2'b00, 2'b00, 1'b1, 1'b1));
    access(32'h4000_0000, 3'b000, 1'b0, 1'b0, 8'h20, 1'b0, 1'b0, "R6 read protected bank");
    chk(32'(wp_status), 0, "R6 read leaves status");
    access(32'h4000_0000, 3'b000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R6 write protected bank");
    chk(32'(wp_status), 1, "R7 status set");
  endtask

  task automatic t_status;
    repeat (3) @(negedge clk);
    chk(32'(wp_status), 1, "R7 status sticky");
    reg_write(5'b10000, 32'h0);
    chk(32'(wp_status), 1, "R7 clear with 0 ignored");
    reg_write(5'b10000, 32'h1);
    chk(32'(wp_status), 0, "R7 cleared");
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'b10000; reg_wdata = 32'h1;
    req_valid = 1'b1; req_addr = 32'h4000_0010; req_at = 3'b000; req_write = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    chk(32'(wp_viol), 1, "R7 violation with clear");
    chk(32'(wp_status), 1, "R7 set wins over clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_addr_mask();
    t_order();
    t_valid();
    t_priority();
    t_at();
    t_ext();
    t_wp();
    t_status();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule